// File: doc/BRIEF.md
# Multi-Device Memory Bank Read Controller

This controller connects a host read port to a bank of several word-wide read-only memory devices that share one address bus and one data bus. The upper bits of the host address choose a device, which gets its own active-low chip-enable. A single active-low output-enable is shared by all devices and acts as the read strobe. Every device that is not selected stays in standby with its outputs in high impedance, so only one device ever drives the shared data bus.

The host holds `req_i` and a stable `req_addr_i` until `rsp_valid_o` pulses, and the word appears on `rsp_data_o` in that same cycle. The host then presents its next request or drops `req_i` in the cycle after the pulse. The chip-enable stays asserted across back-to-back reads to the same device. It is released when the request stream goes idle, so the device returns to standby. When the target device changes, output-enable is raised first and the chip-enables are switched only after that.

Device timing is set by two cycle-count parameters. `T_ACC` is the delay from an address or chip-enable change to valid data. `T_OE` is the shorter delay from the output-enable falling edge to valid data. Output-enable is lowered once `T_ACC - T_OE` cycles have passed since the last address or chip-enable change. The bus is sampled when both waits have run out, which is `T_ACC` cycles after that change. The parameters must satisfy `T_ACC > T_OE >= 1`.

Top module: `bank_rd_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, every bit of `mem_ce_n_o` is 1, `mem_oe_n_o` is 1 and `rsp_valid_o` is 0.
- R2: For a request, the device index is `req_addr_i[HOST_AW-1:DEV_AW]` and the in-device address is `req_addr_i[DEV_AW-1:0]`. Only bit `index` of `mem_ce_n_o` is driven low, and `mem_addr_o` carries the in-device address.
- R3: At most one bit of `mem_ce_n_o` is low in any cycle.
- R4: `rsp_valid_o` rises `T_ACC+1` cycles after a request is presented to the idle controller. `rsp_data_o` then equals the word the selected device drives at `mem_addr_o`.
- R5: `mem_oe_n_o` is low only when exactly one device is selected. Starting from idle, it first goes low `T_ACC-T_OE+1` cycles after the request, and never sooner than `T_ACC-T_OE` cycles after the last address or chip-enable change.
- R6: A request to the same device as the previous read, presented in the cycle after `rsp_valid_o`, keeps that device's chip-enable and `mem_oe_n_o` low without a break. Its response arrives `T_ACC+2` cycles after it is presented.
- R7: A request to a different device makes `mem_oe_n_o` high for at least one cycle before and during the chip-enable change. A chip-enable never changes to a new selection while output-enable is low. The response arrives `T_ACC+3` cycles after the request is presented.
- R8: When `req_i` is low in the cycle after `rsp_valid_o`, all chip-enables and `mem_oe_n_o` go high and stay high until the next request. `rsp_valid_o` stays low in that time.
- R9: `rsp_valid_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Host read request, held until the response |
| req_addr_i | input | HOST_AW | Host word address: device index above the in-device address |
| rsp_valid_o | output | 1 | One-cycle pulse: the read word is on `rsp_data_o` |
| rsp_data_o | output | DW | Word captured from the shared data bus |
| mem_addr_o | output | DEV_AW | Shared device address bus |
| mem_ce_n_o | output | NUM_DEV | Active-low chip-enable, one bit per device |
| mem_oe_n_o | output | 1 | Shared active-low output-enable |
| mem_data_i | input | DW | Shared device data bus |

## Verification
The assertions assume that the host keeps `req_i` high and `req_addr_i` steady from the moment it raises a request until the response pulse. They also assume the host changes these inputs only in the cycle after that pulse, and that the timing parameters keep `T_OE` below `T_ACC`. The bench drives the host inputs only at falling clock edges, and only at the start of a read or directly after it sees the response. It never withdraws a request while a read is in flight. Its device model returns a poison word whenever the access or output-enable delay has not elapsed. A read sampled too early therefore shows up as a data mismatch.

// File: rtl/bank_rd_pkg.sv
package bank_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_RESP,
    ST_DECIDE,
    ST_SWITCH
  } rd_state_e;

endpackage

// File: rtl/bank_rd_decode.sv
// Device index to active-low one-hot chip-enable vector.
module bank_rd_decode #(
  parameter int NUM_DEV = 4,
  parameter int SEL_W   = 2
) (
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_DEV-1:0] ce_n_o
);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign ce_n_o[g] = (sel_i != SEL_W'(g));
  end

endmodule

// File: rtl/bank_rd_timer.sv
// Counts cycles since the last address/select event and since the
// output-enable fall; reports when OE may drop and when data is valid.
module bank_rd_timer #(
  parameter int T_ACC = 6,
  parameter int T_OE  = 2,
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic oe_fall_i,
  input  logic oe_low_i,
  output logic oe_go_o,
  output logic cap_go_o
);

  localparam logic [CNT_W-1:0] ACC_MAX = CNT_W'(T_ACC);
  localparam logic [CNT_W-1:0] OE_MAX  = CNT_W'(T_OE);
  localparam logic [CNT_W-1:0] OE_LEAD = CNT_W'(T_ACC - T_OE);

  logic [CNT_W-1:0] acc_q, oe_q, acc_nxt, oe_nxt;

  assign acc_nxt = (acc_q >= ACC_MAX) ? ACC_MAX : acc_q + 1'b1;
  assign oe_nxt  = (oe_q >= OE_MAX) ? OE_MAX : oe_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      oe_q  <= '0;
    end else begin
      acc_q <= restart_i ? '0 : acc_nxt;
      if (oe_fall_i)     oe_q <= '0;
      else if (oe_low_i) oe_q <= oe_nxt;
      else               oe_q <= '0;
    end
  end

  assign oe_go_o  = (acc_nxt >= OE_LEAD);
  assign cap_go_o = oe_low_i && (acc_nxt >= ACC_MAX) && (oe_nxt >= OE_MAX);

endmodule

// File: rtl/bank_rd_ctrl.sv
module bank_rd_ctrl #(
  parameter int NUM_DEV = 4,
  parameter int DEV_AW  = 12,
  parameter int DW      = 16,
  parameter int T_ACC   = 6,
  parameter int T_OE    = 2,
  localparam int SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int HOST_AW = DEV_AW + SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_i,
  input  logic [HOST_AW-1:0] req_addr_i,
  output logic               rsp_valid_o,
  output logic [DW-1:0]      rsp_data_o,
  output logic [DEV_AW-1:0]  mem_addr_o,
  output logic [NUM_DEV-1:0] mem_ce_n_o,
  output logic               mem_oe_n_o,
  input  logic [DW-1:0]      mem_data_i
);

  import bank_rd_pkg::*;

  localparam int CNT_W = $clog2(T_ACC + 1) + 1;

  rd_state_e          state_q;
  logic [SEL_W-1:0]   sel_q;
  logic [DEV_AW-1:0]  addr_q;
  logic [NUM_DEV-1:0] ce_n_q;
  logic               oe_n_q;
  logic               rsp_valid_q;
  logic [DW-1:0]      rsp_data_q;

  logic [SEL_W-1:0]   req_sel;
  logic [DEV_AW-1:0]  req_low;
  logic [NUM_DEV-1:0] dec_ce_n;
  logic               same_dev, restart, oe_fall, oe_go, cap_go;

  assign req_sel  = req_addr_i[HOST_AW-1:DEV_AW];
  assign req_low  = req_addr_i[DEV_AW-1:0];
  assign same_dev = (req_sel == sel_q);

  bank_rd_decode #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_dec (
    .sel_i  (req_sel),
    .ce_n_o (dec_ce_n)
  );

  // Address/select events: new read from idle, same-device follow-on,
  // or the select change after the output-enable gap.
  assign restart = ((state_q == ST_IDLE) && req_i) ||
                   ((state_q == ST_DECIDE) && req_i && same_dev) ||
                   (state_q == ST_SWITCH);
  assign oe_fall = (state_q == ST_ACCESS) && oe_n_q && oe_go;

  bank_rd_timer #(.T_ACC(T_ACC), .T_OE(T_OE), .CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .oe_fall_i (oe_fall),
    .oe_low_i  (!oe_n_q),
    .oe_go_o   (oe_go),
    .cap_go_o  (cap_go)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sel_q       <= '0;
      addr_q      <= '0;
      ce_n_q      <= '1;
      oe_n_q      <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            sel_q   <= req_sel;
            addr_q  <= req_low;
            ce_n_q  <= dec_ce_n;
            state_q <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (oe_fall) oe_n_q <= 1'b0;
          if (cap_go) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= mem_data_i;
            state_q     <= ST_RESP;
          end
        end
        ST_RESP: begin
          rsp_valid_q <= 1'b0;
          state_q     <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (!req_i) begin
            ce_n_q  <= '1;
            oe_n_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (same_dev) begin
            addr_q  <= req_low;
            state_q <= ST_ACCESS;
          end else begin
            oe_n_q  <= 1'b1;
            state_q <= ST_SWITCH;
          end
        end
        ST_SWITCH: begin
          sel_q   <= req_sel;
          addr_q  <= req_low;
          ce_n_q  <= dec_ce_n;
          state_q <= ST_ACCESS;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign mem_addr_o  = addr_q;
  assign mem_ce_n_o  = ce_n_q;
  assign mem_oe_n_o  = oe_n_q;

endmodule

// File: rtl/bank_rd_ctrl_chk.sv
module bank_rd_ctrl_chk #(
  parameter int NUM_DEV = 4,
  parameter int DEV_AW  = 12,
  parameter int T_ACC   = 6,
  parameter int T_OE    = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               rsp_valid_o,
  input logic [DEV_AW-1:0]  mem_addr_o,
  input logic [NUM_DEV-1:0] mem_ce_n_o,
  input logic               mem_oe_n_o
);

  localparam int AGE_W = $clog2(T_ACC + 2) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(T_ACC);
  localparam logic [AGE_W-1:0] LEAD    = AGE_W'(T_ACC - T_OE);

  logic [DEV_AW-1:0]  addr_prev_q;
  logic [NUM_DEV-1:0] ce_prev_q;
  logic [AGE_W-1:0]   age_q;
  logic               moved;

  assign moved = (mem_addr_o != addr_prev_q) || (mem_ce_n_o != ce_prev_q);

  // age_q = cycles since the last address or chip-enable change
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_prev_q <= '0;
      ce_prev_q   <= '1;
      age_q       <= AGE_MAX;
    end else begin
      addr_prev_q <= mem_addr_o;
      ce_prev_q   <= mem_ce_n_o;
      if (moved)                age_q <= AGE_W'(1);
      else if (age_q < AGE_MAX) age_q <= age_q + 1'b1;
    end
  end

  a_r3_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_ce_n_o));

  a_r5_oe_needs_select: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n_o |-> ($countones(~mem_ce_n_o) == 1));

  a_r5_oe_lead: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n_o) |-> (age_q >= LEAD));

  a_r7_quiet_switch: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mem_ce_n_o) && !(&mem_ce_n_o)) |-> (mem_oe_n_o && $past(mem_oe_n_o)));

  a_r9_one_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

bind bank_rd_ctrl bank_rd_ctrl_chk #(
  .NUM_DEV (NUM_DEV),
  .DEV_AW  (DEV_AW),
  .T_ACC   (T_ACC),
  .T_OE    (T_OE)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .rsp_valid_o (rsp_valid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_oe_n_o  (mem_oe_n_o)
);

// File: tb/bank_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module bank_rd_ctrl_tb_top;

  localparam int NUM_DEV = 4;
  localparam int DEV_AW  = 12;
  localparam int DW      = 16;
  localparam int T_ACC   = 6;
  localparam int T_OE    = 2;
  localparam int HOST_AW = DEV_AW + 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req = 1'b0;
  logic [HOST_AW-1:0] req_addr = '0;
  logic               rsp_valid;
  logic [DW-1:0]      rsp_data;
  logic [DEV_AW-1:0]  mem_addr;
  logic [NUM_DEV-1:0] mem_ce_n;
  logic               mem_oe_n;
  logic [DW-1:0]      mem_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bank_rd_ctrl #(
    .NUM_DEV(NUM_DEV), .DEV_AW(DEV_AW), .DW(DW), .T_ACC(T_ACC), .T_OE(T_OE)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req),
    .req_addr_i  (req_addr),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data),
    .mem_addr_o  (mem_addr),
    .mem_ce_n_o  (mem_ce_n),
    .mem_oe_n_o  (mem_oe_n),
    .mem_data_i  (mem_data)
  );

  // ---------------- device bank model ----------------
  function automatic logic [DW-1:0] pat(input int d, input int a);
    logic [31:0] t;
    t = a * 32'd40503 + d * 32'd7919;
    return t[15:0] ^ 16'h3C5A;
  endfunction

  logic [DEV_AW-1:0]  prev_addr = '0;
  logic [NUM_DEV-1:0] prev_ce   = '1;
  logic               prev_oe   = 1'b1;
  int acc_age = 0;
  int oe_age  = -1;
  int contention = 0;
  int overlap    = 0;

  always @(negedge clk) begin
    prev_addr <= mem_addr;
    prev_ce   <= mem_ce_n;
    prev_oe   <= mem_oe_n;
    if (mem_addr != prev_addr || mem_ce_n != prev_ce) acc_age <= 0;
    else if (acc_age < 1000) acc_age <= acc_age + 1;
    if (mem_oe_n)         oe_age <= -1;
    else if (prev_oe)     oe_age <= 0;
    else if (oe_age < 1000) oe_age <= oe_age + 1;
    if (!rst) begin
      if (!mem_oe_n && $countones(~mem_ce_n) > 1) contention <= contention + 1;
      if (mem_ce_n != prev_ce && !(&mem_ce_n) && (!mem_oe_n || !prev_oe))
        overlap <= overlap + 1;
    end
  end

  always_comb begin
    int idx;
    idx = 0;
    for (int i = 0; i < NUM_DEV; i++) if (!mem_ce_n[i]) idx = i;
    if (!mem_oe_n && $countones(~mem_ce_n) == 1 &&
        acc_age >= T_ACC - 1 && oe_age >= T_OE - 1)
      mem_data = pat(idx, int'(mem_addr));
    else
      mem_data = 16'hEEEE;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [HOST_AW-1:0] mk(input int d, input int a);
    return {2'(d), DEV_AW'(a)};
  endfunction

  // Presents a request at the current falling edge and waits for the response.
  task automatic do_read(input logic [HOST_AW-1:0] a, output int lat,
                         output logic [DW-1:0] data, output bit ce_gap,
                         output bit oe_gap, output int oe_fall_n,
                         output logic [NUM_DEV-1:0] ce_seen,
                         output logic [DEV_AW-1:0] addr_seen);
    int n;
    n = 0; ce_gap = 0; oe_gap = 0; oe_fall_n = -1;
    req = 1'b1;
    req_addr = a;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (&mem_ce_n) ce_gap = 1;
      if (mem_oe_n) oe_gap = 1;
      else if (oe_fall_n < 0) oe_fall_n = n;
    end while (!rsp_valid && n < 100);
    lat = n;
    data = rsp_data;
    ce_seen = mem_ce_n;
    addr_seen = mem_addr;
  endtask

  task automatic go_idle();
    req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(&mem_ce_n, "R1", "ce_n after reset", int'(mem_ce_n), 15);
    chk(mem_oe_n == 1'b1, "R1", "oe_n after reset", int'(mem_oe_n), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_idle_read(input int d, input int a);
    int lat, ofn; logic [DW-1:0] dat; bit cg, og;
    logic [NUM_DEV-1:0] ce; logic [DEV_AW-1:0] ad;
    do_read(mk(d, a), lat, dat, cg, og, ofn, ce, ad);
    chk(ce == ~(NUM_DEV'(1) << d), "R2", "chip-enable decode", int'(ce),
        int'(~(NUM_DEV'(1) << d)));
    chk(ad == DEV_AW'(a), "R2", "device address", int'(ad), a);
    chk(dat == pat(d, a), "R4", "read data", int'(dat), int'(pat(d, a)));
    chk(lat == T_ACC + 1, "R4", "idle read latency", lat, T_ACC + 1);
    chk(ofn == T_ACC - T_OE + 1, "R5", "oe fall cycle", ofn, T_ACC - T_OE + 1);
  endtask

  task automatic t_drop_to_idle();
    bit bad_pulse;
    t_idle_read(1, 12'h05A);
    req = 1'b0;
    bad_pulse = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (rsp_valid) bad_pulse = 1;
    end
    chk(&mem_ce_n, "R8", "ce_n released when idle", int'(mem_ce_n), 15);
    chk(mem_oe_n == 1'b1, "R8", "oe_n released when idle", int'(mem_oe_n), 1);
    chk(!bad_pulse, "R9", "no response while idle", int'(bad_pulse), 0);
  endtask

  task automatic t_same_dev();
    int lat, ofn; logic [DW-1:0] dat; bit cg, og;
    logic [NUM_DEV-1:0] ce; logic [DEV_AW-1:0] ad;
    do_read(mk(2, 12'h100), lat, dat, cg, og, ofn, ce, ad);
    chk(dat == pat(2, 12'h100), "R4", "first read dev2", int'(dat), int'(pat(2, 12'h100)));
    for (int k = 0; k < 2; k++) begin
      int a = (k == 0) ? 12'hFFF : 12'h000;
      do_read(mk(2, a), lat, dat, cg, og, ofn, ce, ad);
      chk(dat == pat(2, a), "R6", "same-device data", int'(dat), int'(pat(2, a)));
      chk(lat == T_ACC + 2, "R6", "same-device latency", lat, T_ACC + 2);
      chk(!cg, "R6", "chip-enable held", int'(cg), 0);
      chk(!og, "R6", "output-enable held", int'(og), 0);
    end
    go_idle();
  endtask

  task automatic t_switch();
    int lat, ofn; logic [DW-1:0] dat; bit cg, og;
    logic [NUM_DEV-1:0] ce; logic [DEV_AW-1:0] ad;
    do_read(mk(0, 12'h3A7), lat, dat, cg, og, ofn, ce, ad);
    do_read(mk(3, 12'hFFF), lat, dat, cg, og, ofn, ce, ad);
    chk(dat == pat(3, 12'hFFF), "R7", "switched data", int'(dat), int'(pat(3, 12'hFFF)));
    chk(lat == T_ACC + 3, "R7", "switch latency", lat, T_ACC + 3);
    chk(og, "R7", "output-enable gap", int'(og), 1);
    chk(ce == 4'b0111, "R2", "top device selected", int'(ce), 7);
    do_read(mk(1, 12'h000), lat, dat, cg, og, ofn, ce, ad);
    chk(dat == pat(1, 0), "R7", "switch back data", int'(dat), int'(pat(1, 0)));
    chk(lat == T_ACC + 3, "R7", "switch back latency", lat, T_ACC + 3);
    go_idle();
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    for (int d = 0; d < NUM_DEV; d++) begin
      t_idle_read(d, 12'h011 * (d + 1));
      go_idle();
    end
    t_drop_to_idle();
    t_same_dev();
    t_switch();
    chk(contention == 0, "R3", "bus contention cycles", contention, 0);
    chk(overlap == 0, "R7", "select change with OE low", overlap, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule